// File: doc/BRIEF.md
# PWM Trip-Zone Fault Controller

This block sits between a PWM generator and the two pins it drives. Six active-low fault inputs can arrive at any time. Each passes through a two-flop synchroniser and is then qualified by two enable masks. The one-shot mask sends a fault to a latch that stays set until software clears it. The cycle-by-cycle mask sends a fault to a latch that drops at the next period boundary, which is marked by the counter-zero strobe. A software strobe can also force a one-shot trip.

While either latch is set, each output takes its own programmed action: drive high, drive low, release to high-impedance, or leave the PWM signal untouched. When neither latch is set, the raw PWM signals pass through with the drivers enabled. Two sticky flags record which class of trip occurred. A single-cycle interrupt pulse marks the onset of each trip.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset both latches and both flags are clear, `irq` is low, and each output equals its raw PWM input with its output-enable high.
- R2: A fault input whose bit is 0 in both `osht_en` and `cbc_en` has no effect on the outputs, flags or `irq`.
- R3: The one-shot latch sets when an input enabled in `osht_en` is asserted. It holds through counter-zero strobes and clears only on an `osht_clr` strobe, and only in a cycle when no such input is asserted.
- R4: The cycle-by-cycle latch sets when an input enabled in `cbc_en` is asserted. It clears on a `cnt_zero` strobe only if no such input is asserted in that cycle, and otherwise holds.
- R5: While tripped, each output follows its 2-bit action code. 00 gives out=0 with oe=0 (high-impedance). 01 gives out=1 with oe=1. 10 gives out=0 with oe=1. 11 passes the raw PWM with oe=1.
- R6: `flag_osht` and `flag_cbc` set when their trip class fires and stay set until a `flag_clr` strobe. `irq` is high for exactly one cycle, in the cycle either latch goes from clear to set.
- R7: A `sw_force` strobe trips the one-shot latch with no fault input asserted.
- R8: A fault input that falls before clock edge k changes the outputs after edge k+2 and not earlier.
- R9: An input enabled in both masks keeps the outputs forced after the cycle-by-cycle latch releases, until the one-shot latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_n | input | 6 | Active-low fault inputs, may be asynchronous |
| osht_en | input | 6 | Per-input one-shot enable |
| cbc_en | input | 6 | Per-input cycle-by-cycle enable |
| pwm_a_in | input | 1 | Raw PWM A |
| pwm_b_in | input | 1 | Raw PWM B |
| cnt_zero | input | 1 | Counter-zero (period boundary) strobe |
| act_a | input | 2 | Trip action for output A |
| act_b | input | 2 | Trip action for output B |
| osht_clr | input | 1 | Software clear of the one-shot latch |
| flag_clr | input | 1 | Software clear of both flags |
| sw_force | input | 1 | Software one-shot trip |
| pwm_a_out | output | 1 | Final output A |
| pwm_a_oe | output | 1 | Output-enable A (0 = high-impedance) |
| pwm_b_out | output | 1 | Final output B |
| pwm_b_oe | output | 1 | Output-enable B |
| flag_osht | output | 1 | Sticky one-shot trip flag |
| flag_cbc | output | 1 | Sticky cycle-by-cycle trip flag |
| irq | output | 1 | Trip onset pulse |

## Verification
The hardest situation to reach is a period boundary that arrives while a cycle-by-cycle fault is still asserted. Here the latch must refuse to release. A related case is one input routed to both classes, where the output must stay forced after the cycle-by-cycle latch drops. The stimulus holds a fault low across a counter-zero strobe and checks that nothing releases. It then removes the fault and waits out the synchroniser delay before pulsing counter-zero again. It finally clears the one-shot latch and expects the outputs to return.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NTRIP = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIP-1:0] trip_n,
  input  logic [NTRIP-1:0] osht_en,
  input  logic [NTRIP-1:0] cbc_en,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic             cnt_zero,
  input  logic [1:0]       act_a,
  input  logic [1:0]       act_b,
  input  logic             osht_clr,
  input  logic             flag_clr,
  input  logic             sw_force,
  output logic             pwm_a_out,
  output logic             pwm_a_oe,
  output logic             pwm_b_out,
  output logic             pwm_b_oe,
  output logic             flag_osht,
  output logic             flag_cbc,
  output logic             irq
);

  logic [NTRIP-1:0] meta_q, sync_q;
  logic osht_lat, cbc_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= trip_n;
      sync_q <= meta_q;
    end

  wire [NTRIP-1:0] fault = ~sync_q;
  wire osht_hit = |(fault & osht_en) | sw_force;
  wire cbc_hit  = |(fault & cbc_en);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osht_lat  <= 1'b0;
      cbc_lat   <= 1'b0;
      flag_osht <= 1'b0;
      flag_cbc  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (osht_hit)      osht_lat <= 1'b1;
      else if (osht_clr) osht_lat <= 1'b0;
      if (cbc_hit)       cbc_lat  <= 1'b1;
      else if (cnt_zero) cbc_lat  <= 1'b0;
      if (osht_hit)      flag_osht <= 1'b1;
      else if (flag_clr) flag_osht <= 1'b0;
      if (cbc_hit)       flag_cbc  <= 1'b1;
      else if (flag_clr) flag_cbc  <= 1'b0;
      irq <= (osht_hit & ~osht_lat) | (cbc_hit & ~cbc_lat);
    end

  wire tripped = osht_lat | cbc_lat;

  function automatic logic [1:0] apply(input logic trip, input logic [1:0] act, input logic raw);
    if (!trip) return {raw, 1'b1};
    case (act)
      2'b00:   return 2'b00;
      2'b01:   return 2'b11;
      2'b10:   return 2'b01;
      default: return {raw, 1'b1};
    endcase
  endfunction

  assign {pwm_a_out, pwm_a_oe} = apply(tripped, act_a, pwm_a_in);
  assign {pwm_b_out, pwm_b_oe} = apply(tripped, act_b, pwm_b_in);

endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osht_lat,
  input logic       cbc_lat,
  input logic       osht_clr,
  input logic       cnt_zero,
  input logic       flag_clr,
  input logic       flag_osht,
  input logic       flag_cbc,
  input logic       irq,
  input logic [1:0] act_a,
  input logic       pwm_a_in,
  input logic       pwm_a_out,
  input logic       pwm_a_oe
);
  // R3
  osht_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osht_lat && !osht_clr |=> osht_lat);
  // R4
  cbc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbc_lat && !cnt_zero |=> cbc_lat);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_osht || flag_cbc) && !flag_clr |=> (flag_osht || flag_cbc));
  // R6
  irq_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osht_lat) |-> irq);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (osht_lat || cbc_lat));
  // R5
  hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osht_lat || cbc_lat) && act_a == 2'b00 |-> !pwm_a_oe);
  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(osht_lat || cbc_lat) |-> (pwm_a_out == pwm_a_in) && pwm_a_oe);
endmodule

bind pwm_fault_guard pwm_fault_guard_chk u_chk (
  .clk, .rst_n, .osht_lat, .cbc_lat, .osht_clr, .cnt_zero, .flag_clr,
  .flag_osht, .flag_cbc, .irq, .act_a, .pwm_a_in, .pwm_a_out, .pwm_a_oe
);

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
  logic clk = 0, rst_n = 0;
  logic [5:0] trip_n = '1, osht_en = '0, cbc_en = '0;
  logic pwm_a_in = 0, pwm_b_in = 0, cnt_zero = 0;
  logic [1:0] act_a = 2'b11, act_b = 2'b11;
  logic osht_clr = 0, flag_clr = 0, sw_force = 0;
  logic pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe, flag_osht, flag_cbc, irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pwm_fault_guard i_pwm_fault_guard (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0;
  endtask

  function automatic logic [3:0] outs();
    return {pwm_a_out, pwm_a_oe, pwm_b_out, pwm_b_oe};
  endfunction

  task automatic t_reset();
    pwm_a_in = 1; pwm_b_in = 0; step(1);
    chk("R1 outputs", outs(), 4'b1101);
    chk("R1 flags", {1'b0, flag_osht, flag_cbc, irq}, 4'h0);
  endtask

  task automatic t_ignored();
    trip_n[2] = 0; act_a = 2'b10; step(5);
    chk("R2 outputs", outs(), 4'b1101);
    chk("R2 flags", {1'b0, flag_osht, flag_cbc, irq}, 4'h0);
    trip_n = '1; step(3);
  endtask

  task automatic t_oneshot();
    osht_en = 6'b000010; act_a = 2'b10; act_b = 2'b00;
    pwm_a_in = 1; pwm_b_in = 1;
    trip_n[1] = 0; step(2);
    chk("R8 not yet", outs(), 4'b1111);
    step(1);
    chk("R5 low/hiz", outs(), 4'b0100);
    chk("R6 onset", {2'b0, flag_osht, irq}, 4'b0011);
    step(1);
    chk("R6 irq one cycle", {3'b0, irq}, 4'b0000);
    pulse(osht_clr); step(1);
    chk("R3 clear while asserted", outs(), 4'b0100);
    trip_n = '1; step(3); pulse(cnt_zero); step(1);
    chk("R3 holds through zero", outs(), 4'b0100);
    pulse(osht_clr);
    chk("R3 cleared", outs(), 4'b1111);
    chk("R6 flag sticky", {3'b0, flag_osht}, 4'b0001);
    pulse(flag_clr);
    chk("R6 flag cleared", {3'b0, flag_osht}, 4'b0000);
    osht_en = '0;
  endtask

  task automatic t_cbc();
    cbc_en = 6'b010000; act_a = 2'b01; act_b = 2'b11;
    pwm_a_in = 0; pwm_b_in = 0;
    trip_n[4] = 0; step(3);
    chk("R5 high/pass", outs(), 4'b1101);
    pwm_b_in = 1; #1;
    chk("R5 pass follows", outs(), 4'b1111);
    chk("R6 cbc flag", {2'b0, flag_cbc, irq}, 4'b0011);
    pulse(cnt_zero); step(1);
    chk("R4 held while asserted", outs(), 4'b1111);
    trip_n = '1; step(4);
    chk("R4 held until zero", outs(), 4'b1111);
    pulse(cnt_zero);
    chk("R4 released", outs(), 4'b0111);
    pulse(flag_clr); cbc_en = '0;
  endtask

  task automatic t_both();
    osht_en = 6'b000001; cbc_en = 6'b000001; act_a = 2'b10; act_b = 2'b11;
    pwm_a_in = 1; pwm_b_in = 0;
    trip_n[0] = 0; step(3);
    chk("R9 forced", outs(), 4'b0101);
    trip_n = '1; step(3); pulse(cnt_zero); step(1);
    chk("R9 one-shot holds", outs(), 4'b0101);
    pulse(osht_clr);
    chk("R9 released", outs(), 4'b1101);
    pulse(flag_clr); osht_en = '0; cbc_en = '0;
  endtask

  task automatic t_force();
    act_a = 2'b00; act_b = 2'b01; pwm_a_in = 1; pwm_b_in = 0;
    pulse(sw_force);
    chk("R7 forced", outs(), 4'b0011);
    chk("R7 flag", {2'b0, flag_osht, irq}, 4'b0011);
    pulse(cnt_zero); step(1);
    chk("R7 holds", outs(), 4'b0011);
    pulse(osht_clr);
    chk("R7 released", outs(), 4'b1101);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset();
    t_ignored();
    t_oneshot();
    t_cbc();
    t_both();
    t_force();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule